// File: doc/BRIEF.md
# Flash Program/Erase Status Flag Register

This block holds the 32-bit status word of a flash program/erase command engine. The engine tells it what happened through one-cycle strobes: a read-verify starting, finishing, pausing or continuing; a verify mismatch; a program or precondition pulse limit running out; an illegal address. It also sends the words read from the array during the first-read and precondition-verify steps. The block turns these strobes into live activity bits and sticky failure bits. Two decoded clear commands remove the sticky bits: a normal clear and a wider one. Eleven further live status lines from the engine are registered into the low bits.

Software sees the word through a small read port only. Nothing can write it. A read strobe returns the current word on the next cycle. The upper fourteen bits always read as zero.

Top module: `flash_status_reg`

## Requirements
- R1: After synchronous reset the word reads 0x00000000, and bits 31..18 read as zero at all times.
- R2: Bit 16 (verify running) sets in the cycle after `rv_start_i` and clears in the cycle after `rv_done_i`.
- R3: `rv_suspend_i` while bit 16 is set clears bit 16 and sets bit 17 (verify paused). A suspend while bit 16 is clear has no effect.
- R4: `rv_resume_i` while bit 17 is set clears bit 17 and sets bit 16. A resume while bit 17 is clear has no effect.
- R5: Bit 15 (verify mismatch) sets on `rv_mismatch_i` and stays set until a clear command arrives.
- R6: Bit 13 (disturb fail) sets on `first_rd_i` when `array_word_i` is not all ones. An all-ones word leaves it clear.
- R7: Bit 12 (program fail) sets on `pgm_limit_fail_i` and is sticky.
- R8: Bit 11 (precondition fail) sets on `pre_limit_fail_i`. It also sets on `pre_vfy_rd_i` when any bit of `array_word_i` is one. An all-zero verify word leaves it clear.
- R9: Bit 14 (bad address) sets on `bad_addr_i` and is sticky.
- R10: `clr_status_i` clears bits 15..11 and leaves bit 17 and bit 16 unchanged.
- R11: `clr_more_i` clears bits 15..11 and also bit 17. It leaves bit 16 unchanged.
- R12: When a set event and a clear for the same bit arrive in one cycle, the bit ends up set.
- R13: Bits 10..0 equal `live_i[10:0]` as sampled one cycle earlier. From bit 10 down, these bits are: erase verify, compact verify, busy, erase active, program active, invalid data, command status, voltage status, erase paused, program paused, sector lock.
- R14: `rd_data_o` carries the word one cycle after `rd_en_i` is high, and it is zero in a cycle after `rd_en_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rv_start_i | input | 1 | Read-verify begins |
| rv_done_i | input | 1 | Read-verify completes |
| rv_suspend_i | input | 1 | Suspend request processed |
| rv_resume_i | input | 1 | Resume request processed |
| rv_mismatch_i | input | 1 | Read-verify data mismatch |
| first_rd_i | input | 1 | First read of an address during sector programming |
| pgm_limit_fail_i | input | 1 | Word still unprogrammed at the pulse limit |
| pre_limit_fail_i | input | 1 | Sector still not preconditioned at the pulse limit |
| pre_vfy_rd_i | input | 1 | Precondition-verify read valid |
| array_word_i | input | DATA_W | Word read from the array |
| bad_addr_i | input | 1 | Illegal address detected |
| clr_status_i | input | 1 | Clear command for the failure flags |
| clr_more_i | input | 1 | Wider clear command, also clears the pause flag |
| live_i | input | LIVE_W | Live engine status lines |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid one cycle after the strobe |

## Verification
On every cycle the assertions check the following. The reserved field is zero. A start or a mismatch lands in the next cycle. A suspend moves a running verify into the paused state. Sticky failures hold while no clear arrives. A set wins over a clear given in the same cycle. The low bits follow the live lines, and the read port returns the previous word or zero. Some behaviour only the bench scenarios can show: that an idle suspend or a stray resume leaves the word untouched, how the two clear commands differ in reach, and that the disturb and precondition tests decide on the data word.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned LIVE_W = 11;
    localparam int unsigned RSVD_W = WORD_W - LIVE_W - 7;

    // Order of the sticky failure group, low index = lowest bit position.
    localparam int unsigned FAIL_PRE  = 0;
    localparam int unsigned FAIL_PGM  = 1;
    localparam int unsigned FAIL_DIST = 2;
    localparam int unsigned FAIL_ADDR = 3;
    localparam int unsigned FAIL_N    = 4;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic              vfy_paused;
        logic              vfy_running;
        logic              vfy_mismatch;
        logic [FAIL_N-1:0] fails;
        logic [LIVE_W-1:0] live;
    } stat_word_t;

    typedef struct packed {
        logic start;
        logic done;
        logic suspend;
        logic resume;
        logic mismatch;
    } vfy_evt_t;

    typedef struct packed {
        logic status;
        logic more;
    } clr_cmd_t;

    function automatic logic next_flag(input logic q, input logic set, input logic clr);
        // Set has priority so that a fresh event is never dropped.
        if (set)      return 1'b1;
        else if (clr) return 1'b0;
        else          return q;
    endfunction

endpackage

// File: rtl/fstat_sticky_bit.sv
module fstat_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    import fstat_pkg::*;

    logic q;

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= next_flag(q, set_i, clr_i);
    end

    assign q_o = q;
endmodule

// File: rtl/fstat_vfy_tracker.sv
module fstat_vfy_tracker (
    input  logic                 clk,
    input  logic                 rst,
    input  fstat_pkg::vfy_evt_t  evt_i,
    input  fstat_pkg::clr_cmd_t  clr_i,
    output logic                 running_o,
    output logic                 paused_o,
    output logic                 mismatch_o
);
    import fstat_pkg::*;

    logic run_q, pause_q;
    logic run_set, run_clr, pause_set, pause_clr;

    always_comb begin
        pause_set = evt_i.suspend & run_q;
        pause_clr = (evt_i.resume & pause_q) | clr_i.more;
        run_set   = evt_i.start | (evt_i.resume & pause_q);
        run_clr   = evt_i.done | (evt_i.suspend & run_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            pause_q <= 1'b0;
        end else begin
            run_q   <= next_flag(run_q, run_set, run_clr);
            pause_q <= next_flag(pause_q, pause_set, pause_clr);
        end
    end

    fstat_sticky_bit u_mismatch (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i.mismatch),
        .clr_i (clr_i.status | clr_i.more),
        .q_o   (mismatch_o)
    );

    assign running_o = run_q;
    assign paused_o  = pause_q;
endmodule

// File: rtl/fstat_fail_bank.sv
module fstat_fail_bank #(
    parameter int unsigned DATA_W = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        first_rd_i,
    input  logic                        pgm_limit_fail_i,
    input  logic                        pre_limit_fail_i,
    input  logic                        pre_vfy_rd_i,
    input  logic [DATA_W-1:0]           array_word_i,
    input  logic                        bad_addr_i,
    input  fstat_pkg::clr_cmd_t         clr_i,
    output logic [fstat_pkg::FAIL_N-1:0] fails_o
);
    import fstat_pkg::*;

    logic [FAIL_N-1:0] set_v;
    logic              word_all_ones;
    logic              word_any_one;
    logic              clr_any;

    always_comb begin
        word_all_ones         = &array_word_i;
        word_any_one          = |array_word_i;
        set_v                 = '0;
        set_v[FAIL_PRE]       = pre_limit_fail_i | (pre_vfy_rd_i & word_any_one);
        set_v[FAIL_PGM]       = pgm_limit_fail_i;
        set_v[FAIL_DIST]      = first_rd_i & ~word_all_ones;
        set_v[FAIL_ADDR]      = bad_addr_i;
        clr_any               = clr_i.status | clr_i.more;
    end

    for (genvar g = 0; g < FAIL_N; g++) begin : g_fail
        fstat_sticky_bit u_bit (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[g]),
            .clr_i (clr_any),
            .q_o   (fails_o[g])
        );
    end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LIVE_W = fstat_pkg::LIVE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rv_start_i,
    input  logic              rv_done_i,
    input  logic              rv_suspend_i,
    input  logic              rv_resume_i,
    input  logic              rv_mismatch_i,
    input  logic              first_rd_i,
    input  logic              pgm_limit_fail_i,
    input  logic              pre_limit_fail_i,
    input  logic              pre_vfy_rd_i,
    input  logic [DATA_W-1:0] array_word_i,
    input  logic              bad_addr_i,
    input  logic              clr_status_i,
    input  logic              clr_more_i,
    input  logic [LIVE_W-1:0] live_i,
    input  logic              rd_en_i,
    output logic [31:0]       rd_data_o
);
    import fstat_pkg::*;

    vfy_evt_t          vfy_evt;
    clr_cmd_t          clr_cmd;
    logic              vfy_running, vfy_paused, vfy_mismatch;
    logic [FAIL_N-1:0] fails;
    logic [LIVE_W-1:0] live_q;
    stat_word_t        status_img;
    logic [31:0]       rd_q;

    always_comb begin
        vfy_evt.start    = rv_start_i;
        vfy_evt.done     = rv_done_i;
        vfy_evt.suspend  = rv_suspend_i;
        vfy_evt.resume   = rv_resume_i;
        vfy_evt.mismatch = rv_mismatch_i;
        clr_cmd.status   = clr_status_i;
        clr_cmd.more     = clr_more_i;
    end

    fstat_vfy_tracker u_vfy (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (vfy_evt),
        .clr_i      (clr_cmd),
        .running_o  (vfy_running),
        .paused_o   (vfy_paused),
        .mismatch_o (vfy_mismatch)
    );

    fstat_fail_bank #(.DATA_W(DATA_W)) u_fails (
        .clk              (clk),
        .rst              (rst),
        .first_rd_i       (first_rd_i),
        .pgm_limit_fail_i (pgm_limit_fail_i),
        .pre_limit_fail_i (pre_limit_fail_i),
        .pre_vfy_rd_i     (pre_vfy_rd_i),
        .array_word_i     (array_word_i),
        .bad_addr_i       (bad_addr_i),
        .clr_i            (clr_cmd),
        .fails_o          (fails)
    );

    always_ff @(posedge clk) begin
        if (rst) live_q <= '0;
        else     live_q <= live_i;
    end

    always_comb begin
        status_img              = '0;
        status_img.vfy_paused   = vfy_paused;
        status_img.vfy_running  = vfy_running;
        status_img.vfy_mismatch = vfy_mismatch;
        status_img.fails        = fails;
        status_img.live         = fstat_pkg::LIVE_W'(live_q);
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_q <= '0;
        else if (rd_en_i) rd_q <= status_img;
        else              rd_q <= '0;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/flash_status_reg_sva.sv
module flash_status_reg_sva #(
    parameter int unsigned LIVE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              rv_start_i,
    input logic              rv_suspend_i,
    input logic              rv_resume_i,
    input logic              rv_mismatch_i,
    input logic              bad_addr_i,
    input logic              clr_status_i,
    input logic              clr_more_i,
    input logic [LIVE_W-1:0] live_i,
    input logic              rd_en_i,
    input logic [31:0]       rd_data_o,
    input logic [31:0]       img
);
    // R1: reserved field of the read data never carries a one
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[31:18] == '0);

    // R2: a start shows as running in the next cycle
    a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
        rv_start_i |=> img[16]);

    // R3: a suspend during a running verify moves it to paused
    a_r3_suspend_pauses: assert property (@(posedge clk) disable iff (rst)
        (rv_suspend_i && img[16] && !rv_start_i && !rv_resume_i) |=> (!img[16] && img[17]));

    // R5: mismatch lands in the next cycle
    a_r5_mismatch_sets: assert property (@(posedge clk) disable iff (rst)
        rv_mismatch_i |=> img[15]);

    // R5, R7, R8, R9: failure flags hold without a clear
    a_r5_fails_sticky: assert property (@(posedge clk) disable iff (rst)
        (!clr_status_i && !clr_more_i) |=> ((img[15:11] & $past(img[15:11])) == $past(img[15:11])));

    // R11: the wider clear removes the pause flag unless a new pause arrives
    a_r11_more_clears_pause: assert property (@(posedge clk) disable iff (rst)
        (clr_more_i && !rv_suspend_i) |=> !img[17]);

    // R12: bad-address set wins against any clear
    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
        bad_addr_i |=> img[14]);

    // R13: low bits follow the live lines one cycle later
    a_r13_live_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (img[LIVE_W-1:0] == $past(live_i)));

    // R14: read returns the previous word, idle returns zero
    a_r14_read_word: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> (rd_data_o == $past(img)));

    a_r14_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> (rd_data_o == '0));
endmodule

bind flash_status_reg flash_status_reg_sva #(.LIVE_W(LIVE_W)) u_sva (
    .clk           (clk),
    .rst           (rst),
    .rv_start_i    (rv_start_i),
    .rv_suspend_i  (rv_suspend_i),
    .rv_resume_i   (rv_resume_i),
    .rv_mismatch_i (rv_mismatch_i),
    .bad_addr_i    (bad_addr_i),
    .clr_status_i  (clr_status_i),
    .clr_more_i    (clr_more_i),
    .live_i        (live_i),
    .rd_en_i       (rd_en_i),
    .rd_data_o     (rd_data_o),
    .img           (status_img)
);

// File: tb/flash_status_reg_tb.sv
module flash_status_reg_tb;
    localparam int DATA_W = 64;
    localparam int LIVE_W = 11;
    localparam logic [31:0] B_PAUSE = 32'h1 << 17;
    localparam logic [31:0] B_RUN   = 32'h1 << 16;
    localparam logic [31:0] B_MISM  = 32'h1 << 15;
    localparam logic [31:0] B_ADDR  = 32'h1 << 14;
    localparam logic [31:0] B_DIST  = 32'h1 << 13;
    localparam logic [31:0] B_PGM   = 32'h1 << 12;
    localparam logic [31:0] B_PRE   = 32'h1 << 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rv_start_i = 0, rv_done_i = 0, rv_suspend_i = 0, rv_resume_i = 0, rv_mismatch_i = 0;
    logic first_rd_i = 0, pgm_limit_fail_i = 0, pre_limit_fail_i = 0, pre_vfy_rd_i = 0;
    logic [DATA_W-1:0] array_word_i = '0;
    logic bad_addr_i = 0, clr_status_i = 0, clr_more_i = 0;
    logic [LIVE_W-1:0] live_i = '0;
    logic rd_en_i = 0;
    logic [31:0] rd_data_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_status_reg #(.DATA_W(DATA_W), .LIVE_W(LIVE_W)) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic read_word(output logic [31:0] v);
        rd_en_i = 1'b1;
        tick();
        rd_en_i = 1'b0;
        v = rd_data_o;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        read_word(v);
        check("R1 reset value", v, 32'h0);
        tick();
        check("R14 idle read data", rd_data_o, 32'h0);
    endtask

    task automatic t_run_done();
        logic [31:0] v;
        rv_start_i = 1; tick(); rv_start_i = 0;
        read_word(v); check("R2 start sets running", v, B_RUN);
        rv_done_i = 1; tick(); rv_done_i = 0;
        read_word(v); check("R2 done clears running", v, 32'h0);
    endtask

    task automatic t_pause_resume();
        logic [31:0] v;
        rv_suspend_i = 1; tick(); rv_suspend_i = 0;
        read_word(v); check("R3 idle suspend ignored", v, 32'h0);
        rv_resume_i = 1; tick(); rv_resume_i = 0;
        read_word(v); check("R4 resume without pause ignored", v, 32'h0);
        rv_start_i = 1; tick(); rv_start_i = 0;
        rv_suspend_i = 1; tick(); rv_suspend_i = 0;
        read_word(v); check("R3 suspend pauses verify", v, B_PAUSE);
        rv_resume_i = 1; tick(); rv_resume_i = 0;
        read_word(v); check("R4 resume restarts verify", v, B_RUN);
        rv_done_i = 1; tick(); rv_done_i = 0;
        read_word(v); check("R2 done after resume", v, 32'h0);
    endtask

    task automatic t_mismatch();
        logic [31:0] v;
        rv_mismatch_i = 1; tick(); rv_mismatch_i = 0;
        read_word(v); check("R5 mismatch sets", v, B_MISM);
        repeat (5) tick();
        read_word(v); check("R5 mismatch sticky", v, B_MISM);
        clr_status_i = 1; tick(); clr_status_i = 0;
        read_word(v); check("R10 clear-status clears mismatch", v, 32'h0);
    endtask

    task automatic t_fail_flags();
        logic [31:0] v;
        array_word_i = '1;
        first_rd_i = 1; tick(); first_rd_i = 0;
        read_word(v); check("R6 all-ones first read no fail", v, 32'h0);
        array_word_i = ~(64'h1 << 37);
        first_rd_i = 1; tick(); first_rd_i = 0;
        read_word(v); check("R6 disturb fail", v, B_DIST);
        pgm_limit_fail_i = 1; tick(); pgm_limit_fail_i = 0;
        read_word(v); check("R7 program fail", v, B_DIST | B_PGM);
        array_word_i = '0;
        pre_vfy_rd_i = 1; tick(); pre_vfy_rd_i = 0;
        read_word(v); check("R8 zero verify word no fail", v, B_DIST | B_PGM);
        array_word_i = 64'h1 << 63;
        pre_vfy_rd_i = 1; tick(); pre_vfy_rd_i = 0;
        read_word(v); check("R8 verify word with a one", v, B_DIST | B_PGM | B_PRE);
        bad_addr_i = 1; tick(); bad_addr_i = 0;
        read_word(v); check("R9 bad address", v, B_DIST | B_PGM | B_PRE | B_ADDR);
        rv_start_i = 1; tick(); rv_start_i = 0;
        rv_suspend_i = 1; tick(); rv_suspend_i = 0;
        clr_status_i = 1; tick(); clr_status_i = 0;
        read_word(v); check("R10 clear-status keeps pause", v, B_PAUSE);
        pre_limit_fail_i = 1; tick(); pre_limit_fail_i = 0;
        read_word(v); check("R8 precondition limit fail", v, B_PAUSE | B_PRE);
        clr_more_i = 1; tick(); clr_more_i = 0;
        read_word(v); check("R11 clear-more clears pause and fails", v, 32'h0);
        rv_start_i = 1; tick(); rv_start_i = 0;
        clr_more_i = 1; tick(); clr_more_i = 0;
        read_word(v); check("R11 clear-more keeps running", v, B_RUN);
        rv_done_i = 1; tick(); rv_done_i = 0;
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        rv_mismatch_i = 1; clr_status_i = 1; tick(); rv_mismatch_i = 0; clr_status_i = 0;
        read_word(v); check("R12 mismatch beats clear-status", v, B_MISM);
        rv_start_i = 1; tick(); rv_start_i = 0;
        rv_suspend_i = 1; clr_more_i = 1; tick(); rv_suspend_i = 0; clr_more_i = 0;
        read_word(v); check("R12 pause beats clear-more", v, B_PAUSE);
        bad_addr_i = 1; clr_more_i = 1; tick(); bad_addr_i = 0; clr_more_i = 0;
        read_word(v); check("R12 bad address beats clear-more", v, B_ADDR);
        clr_more_i = 1; tick(); clr_more_i = 0;
        read_word(v); check("R11 final clear-more", v, 32'h0);
    endtask

    task automatic t_live();
        logic [31:0] v;
        live_i = 11'h5A3; tick();
        read_word(v); check("R13 live bits", v, 32'h0000_05A3);
        live_i = 11'h7FF;
        rv_start_i = 1; rv_mismatch_i = 1; bad_addr_i = 1; tick();
        rv_start_i = 0; rv_mismatch_i = 0; bad_addr_i = 0;
        read_word(v);
        check("R1 reserved zero with all flags", v & 32'hFFFC_0000, 32'h0);
        check("R13 live all ones", v, B_RUN | B_MISM | B_ADDR | 32'h7FF);
        tick();
        check("R14 data zero after read", rd_data_o, 32'h0);
        live_i = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_run_done();
        t_pause_resume();
        t_mismatch();
        t_fail_flags();
        t_set_wins();
        t_live();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule